// File: doc/BRIEF.md
# Addressed Serial Control-Bus Slave

This block is a slave on a three-wire synchronous serial bus: a bus clock, a chip-enable and a data-in line, plus a data-return line that can only pull low. While chip-enable is low the host shifts in an 8-bit address. When chip-enable rises, the slave compares that address with three fixed codes and enters one mode for the rest of the frame. The modes are writing a 16-bit control word, shifting a status word back to the host, or passing bytes on to a downstream CRC checker. The frame ends when chip-enable falls.

All three bus lines are brought into the system clock domain through two-stage synchronizers, and their edges are detected there. The bus must therefore run well below the system clock rate; each bus phase has to last several system clock cycles. The block's outputs are a latched control register, a one-cycle byte strobe with its data for the CRC checker, and a pull-low enable for the open-drain return line. The status word to be read back is an input.

Top module: `serial_ctrl_slave`

## Requirements
- R1: Address bits are sampled on rising bus-clock edges while chip-enable is low. The first bit received becomes address bit 0 and the eighth becomes bit 7. The code 8'hFA selects control write, 8'hFB selects status read and 8'hFC selects the byte stream.
- R2: In control-write mode, data bits are sampled on rising bus-clock edges, and the first bit received becomes bit 0 of the word. `ctrl_word` changes only when chip-enable falls, never while bits are still arriving.
- R3: `ctrl_word` is written only when exactly 16 data bits have arrived in the frame. A frame with 15 or with 17 bits leaves it unchanged.
- R4: In status-read mode, `stat_word` is captured when chip-enable rises. Each falling bus-clock edge then presents one bit, most significant bit first. `sdo_pull` is 1 exactly when the bit presented is 0.
- R5: `sdo_pull` is 0 outside status-read mode. It is also 0 after all 16 status bits have been presented.
- R6: In stream mode, each group of 8 received bits gives a `byte_vld` pulse, with the first bit of the group in `byte_data` bit 0.
- R7: In stream mode, a partial trailing byte of fewer than 8 bits produces no strobe when chip-enable falls.
- R8: Any address other than the three codes is ignored. No control write takes place, no byte strobe fires and `sdo_pull` stays 0.
- R9: After reset, `ctrl_word` is 0, `byte_vld` is 0 and `sdo_pull` is 0.
- R10: `byte_vld` is high for exactly one system clock cycle per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk | input | 1 | Serial bus clock |
| bus_ce | input | 1 | Chip-enable: low for the address phase, high for the data phase |
| bus_din | input | 1 | Serial data from the host |
| stat_word | input | STAT_W | Status word returned in read mode |
| ctrl_word | output | CTRL_W | Latched control register |
| byte_vld | output | 1 | One-cycle strobe for a completed stream byte |
| byte_data | output | BYTE_W | Byte handed to the CRC checker |
| sdo_pull | output | 1 | 1 drives the open-drain return line low |

## Verification
On every cycle, the assertions check four things. The return line is pulled low only in read mode. Each byte strobe lasts one cycle and comes from stream mode. The control register changes only at a chip-enable fall that ends a 16-bit write frame. An address that matches no code leaves the block idle. Only the bench scenarios can show the rest: the exact bit order and values of the captured words and bytes, the status snapshot taken at the mode decision, the release after the last status bit, and the dropping of a partial trailing byte.

// File: rtl/serial_ctrl_slave.sv
module serial_ctrl_slave #(
  parameter int CTRL_W = 16,
  parameter int STAT_W = 16,
  parameter int BYTE_W = 8,
  parameter logic [7:0] CODE_WR = 8'hFA,
  parameter logic [7:0] CODE_RD = 8'hFB,
  parameter logic [7:0] CODE_ST = 8'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk,
  input  logic              bus_ce,
  input  logic              bus_din,
  input  logic [STAT_W-1:0] stat_word,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data,
  output logic              sdo_pull
);
  localparam int CNT_W = $clog2(CTRL_W + 2);
  localparam int BC_W  = $clog2(BYTE_W);
  localparam int RC_W  = $clog2(STAT_W + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CTRL_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CTRL_W);
  localparam logic [BC_W-1:0]  BC_LAST  = BC_W'(BYTE_W - 1);

  typedef enum logic [1:0] {M_IDLE = 2'd0, M_WR = 2'd1, M_RD = 2'd2, M_ST = 2'd3} mode_t;

  logic [2:0] ck_p, ce_p;
  logic [1:0] di_p;
  logic       ck_rise, ck_fall, ce_rise, ce_fall, din;
  mode_t      mode;
  logic [7:0] addr;
  logic [CTRL_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic [BC_W-1:0]   bcnt;
  logic [STAT_W-1:0] rd_sh;
  logic [RC_W-1:0]   rd_left;

  assign ck_rise = ck_p[1] & ~ck_p[2];
  assign ck_fall = ~ck_p[1] & ck_p[2];
  assign ce_rise = ce_p[1] & ~ce_p[2];
  assign ce_fall = ~ce_p[1] & ce_p[2];
  assign din     = di_p[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_p <= '0;
      ce_p <= '0;
      di_p <= '0;
    end else begin
      ck_p <= {ck_p[1:0], bus_clk};
      ce_p <= {ce_p[1:0], bus_ce};
      di_p <= {di_p[0], bus_din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= M_IDLE;
      addr    <= '0;
      sh      <= '0;
      cnt     <= '0;
      bcnt    <= '0;
      ctrl_word <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      rd_sh   <= '0;
      rd_left <= '0;
      sdo_pull <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (ce_rise) begin
        cnt  <= '0;
        bcnt <= '0;
        if (addr == CODE_WR)      mode <= M_WR;
        else if (addr == CODE_RD) begin
          mode    <= M_RD;
          rd_sh   <= stat_word;
          rd_left <= RC_W'(STAT_W);
        end
        else if (addr == CODE_ST) mode <= M_ST;
        else                      mode <= M_IDLE;
      end else if (ce_fall) begin
        if (mode == M_WR && cnt == CNT_FULL) ctrl_word <= sh;
        mode     <= M_IDLE;
        sdo_pull <= 1'b0;
      end else if (ck_rise) begin
        if (!ce_p[1]) addr <= {din, addr[7:1]};
        else if (mode == M_WR || mode == M_ST) begin
          sh <= {din, sh[CTRL_W-1:1]};
          if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
          if (mode == M_ST) begin
            if (bcnt == BC_LAST) begin
              bcnt      <= '0;
              byte_vld  <= 1'b1;
              byte_data <= {din, sh[CTRL_W-1 -: BYTE_W-1]};
            end else bcnt <= bcnt + 1'b1;
          end
        end
      end else if (ck_fall && mode == M_RD) begin
        if (rd_left != '0) begin
          sdo_pull <= ~rd_sh[STAT_W-1];
          rd_sh    <= {rd_sh[STAT_W-2:0], 1'b0};
          rd_left  <= rd_left - 1'b1;
        end else sdo_pull <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_ctrl_slave_chk.sv
module serial_ctrl_slave_chk #(
  parameter int CTRL_W = 16,
  parameter int CNT_W = 5,
  parameter logic [7:0] CODE_WR = 8'hFA,
  parameter logic [7:0] CODE_RD = 8'hFB,
  parameter logic [7:0] CODE_ST = 8'hFC
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              ce_rise,
  input logic              ce_fall,
  input logic [7:0]        addr,
  input logic [CNT_W-1:0]  cnt,
  input logic              byte_vld,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic              sdo_pull
);
  a_r5_pull_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2) |-> !sdo_pull);

  a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  a_r6_strobe_from_stream: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(mode) == 2'd3);

  a_r3_ctrl_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_word) |-> $past(ce_fall && mode == 2'd1 && cnt == CNT_W'(CTRL_W)));

  a_r8_unknown_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_rise && addr != CODE_WR && addr != CODE_RD && addr != CODE_ST) |=> mode == 2'd0);
endmodule

bind serial_ctrl_slave serial_ctrl_slave_chk #(
  .CTRL_W(CTRL_W), .CNT_W(CNT_W),
  .CODE_WR(CODE_WR), .CODE_RD(CODE_RD), .CODE_ST(CODE_ST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ce_rise(ce_rise), .ce_fall(ce_fall),
  .addr(addr), .cnt(cnt), .byte_vld(byte_vld), .ctrl_word(ctrl_word), .sdo_pull(sdo_pull)
);

// File: tb/test_serial_ctrl_slave.sv
module test_serial_ctrl_slave;
  localparam int H = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_clk = 1'b0, bus_ce = 1'b0, bus_din = 1'b0;
  logic [15:0] stat_word = '0;
  logic [15:0] ctrl_word;
  logic        byte_vld, sdo_pull;
  logic [7:0]  byte_data;
  int nvec = 0, nerr = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  serial_ctrl_slave i_serial_ctrl_slave (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_ce(bus_ce), .bus_din(bus_din),
    .stat_word(stat_word), .ctrl_word(ctrl_word), .byte_vld(byte_vld),
    .byte_data(byte_data), .sdo_pull(sdo_pull)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bit_out(input logic b);
    bus_din = b; wt(H);
    bus_clk = 1'b1; wt(H);
    bus_clk = 1'b0; wt(H);
  endtask

  task automatic start(input logic [7:0] a);
    bus_ce = 1'b0; wt(H);
    for (int i = 0; i < 8; i++) bit_out(a[i]);
    bus_ce = 1'b1; wt(H);
  endtask

  task automatic stop();
    bus_ce = 1'b0; wt(2*H);
  endtask

  task automatic write_bits(input logic [31:0] d, input int n);
    for (int i = 0; i < n; i++) bit_out(d[i]);
  endtask

  task automatic stream(input logic [7:0] bytes[], input int tail);
    start(8'hFC);
    foreach (bytes[k]) begin
      exp_q.push_back(bytes[k]);
      write_bits({24'h0, bytes[k]}, 8);
    end
    write_bits(32'h15, tail);
    stop();
    wt(H);
    chk(exp_q.size() == 0, "R6/R7 stream bytes all seen, none extra", exp_q.size(), 0);
  endtask

  task automatic read_check(input logic [15:0] s);
    stat_word = s;
    start(8'hFB);
    stat_word = ~s;
    for (int i = 15; i >= 0; i--) begin
      bus_clk = 1'b1; wt(H);
      bus_clk = 1'b0; wt(H);
      chk(sdo_pull == ~s[i], "R4 status bit", sdo_pull, ~s[i]);
    end
    bus_clk = 1'b1; wt(H);
    bus_clk = 1'b0; wt(H);
    chk(sdo_pull == 1'b0, "R5 released after last bit", sdo_pull, 0);
    stop();
    chk(sdo_pull == 1'b0, "R5 released after frame", sdo_pull, 0);
  endtask

  int run_len = 0;
  always @(negedge clk) begin
    if (byte_vld) begin
      run_len++;
      if (run_len == 2) chk(1'b0, "R10 strobe longer than one cycle", 1, 0);
      if (run_len == 1) begin
        if (exp_q.size() == 0) chk(1'b0, "R7/R8 unexpected byte strobe", byte_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(byte_data == e, "R6 byte value", byte_data, e);
        end
      end
    end else run_len = 0;
    if (rst_n && !bus_ce && sdo_pull) chk(1'b0, "R5 pull outside frame", 1, 0);
  end

  initial begin
    wt(4); rst_n = 1'b1; wt(2);
    chk(ctrl_word == 16'h0, "R9 reset ctrl", ctrl_word, 0);
    chk(byte_vld == 1'b0, "R9 reset strobe", byte_vld, 0);
    chk(sdo_pull == 1'b0, "R9 reset pull", sdo_pull, 0);

    start(8'hFA); write_bits(32'hA53C, 16);
    chk(ctrl_word == 16'h0, "R2 no update before ce fall", ctrl_word, 0);
    stop();
    chk(ctrl_word == 16'hA53C, "R1 R2 control write", ctrl_word, 16'hA53C);

    start(8'hFA); write_bits(32'h1234, 15); stop();
    chk(ctrl_word == 16'hA53C, "R3 short frame", ctrl_word, 16'hA53C);
    start(8'hFA); write_bits(32'h1_5678, 17); stop();
    chk(ctrl_word == 16'hA53C, "R3 long frame", ctrl_word, 16'hA53C);
    start(8'hFA); write_bits(32'h0F81, 16); stop();
    chk(ctrl_word == 16'h0F81, "R2 second write", ctrl_word, 16'h0F81);

    stat_word = 16'h0000;
    start(8'hFE); write_bits(32'hFFFF, 16); stop();
    chk(ctrl_word == 16'h0F81, "R8 unknown address no write", ctrl_word, 16'h0F81);
    start(8'h5A); write_bits(32'h0000, 16);
    chk(sdo_pull == 1'b0, "R8 unknown address no pull", sdo_pull, 0);
    stop();
    chk(ctrl_word == 16'h0F81, "R8 near-match address no write", ctrl_word, 16'h0F81);

    read_check(16'h9C35);
    read_check(16'h00FF);

    stream('{8'hC3, 8'h01, 8'h80}, 5);
    stream('{8'h7E}, 0);

    start(8'hFB); write_bits(32'hFFFF, 2); stop();
    chk(ctrl_word == 16'h0F81, "R1 read frame leaves control", ctrl_word, 16'h0F81);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule